// File: doc/BRIEF.md
# Quad DAC Synchronous Load Controller

This block sits between a register bus and four DAC channels and decides when new codes reach the converters. Every channel is double-buffered. A bus write lands in the channel's holding register, and the value moves into the output register that drives the converter only when an update is triggered. Software picks how updates are grouped through a configuration register. One data write can refresh its own channel, a pair of channels, or all four together. In a fourth mode, data writes trigger nothing, and a self-clearing strobe register updates any set of channels at once.

An external active-low load pin can take over. While its enable input is high, the grouping modes and the strobes are ignored. A synchronized falling edge on the pin then refreshes all four channels. The block also presents per-channel range bits and per-pair reference-select bits as static outputs, taken from the two control registers.

The bus has an address, a write strobe, write data and combinational read data. Channel data registers sit at four consecutive addresses starting at `CH_BASE`. The configuration register and the strobe register sit at fixed addresses of their own.

Top module: `qdac_load_ctrl`

## Requirements
- R1: After reset, all four output codes, the range outputs, the reference outputs and every register read return 0.
- R2: The configuration register at 0x1B reads back bits 5:0 as written. Bits 7:6 always read 0 and are ignored on write. Output `range_x2[i]` equals configuration bit i, where bit 0 is channel A and bit 3 is channel D.
- R3: With configuration bits 5:4 = 00, a data write to channel i updates output i only.
- R4: With bits 5:4 = 01, a write to B updates A and B, and a write to D updates C and D. Writes to A or C update no output.
- R5: With bits 5:4 = 10, a write to D updates all four outputs. Writes to A, B or C update none.
- R6: With bits 5:4 = 11, data writes update nothing. Writing the strobe register at 0x1C with bit i set (bits 0..3 for A..D) updates channel i, and several bits may be set in one write. In the other modes, strobe bits 3:0 have no effect.
- R7: Strobe register bits 3:0 always read 0. Bit 4 selects the internal reference for A/B and drives `vref_int[0]`. Bit 5 does the same for C/D and drives `vref_int[1]`. A value of 1 means internal. Bits 7:6 read 0.
- R8: While `ext_load_en` is 1, data writes and strobes update nothing. A falling edge on `ext_load_n` updates all four outputs within 4 clock edges after the pin goes low.
- R9: A triggering write is captured on the first rising edge with `bus_wr` high. The output changes on the following edge and carries the newly written value.
- R10: A write to an address that matches no register changes no register and no output.
- R11: Reading a channel address returns that channel's holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | DATA_W | Write data; control registers use the low byte |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| ext_load_en | input | 1 | 1 hands update control to the external load pin |
| ext_load_n | input | 1 | Asynchronous active-low load pin |
| dac_code | output | 4*DATA_W | Output codes; channel A is in the low bits |
| range_x2 | output | 4 | Per-channel range select, 1 = doubled range |
| vref_int | output | 2 | Per-pair reference select, 1 = internal |

## Verification
Some properties are checked on every cycle. In pair mode, each update request sets zero or two channels. In all-channels mode it sets zero or four. The pin path requests nothing without a synchronized edge. An output register never moves unless it has a pending load. The reserved and self-clearing read bits stay zero. Other behaviour only shows up in the bench's scenarios: which channels a given write or strobe pattern reaches, that the newly written value is what gets transferred, the exact two-edge latency, and that decode misses leave every register untouched.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NUM_CH = 4;
    localparam int CH_IDX_W = 2;

    typedef enum logic [1:0] {
        GRP_SINGLE = 2'b00,
        GRP_PAIR   = 2'b01,
        GRP_ALL    = 2'b10,
        GRP_STROBE = 2'b11
    } grp_mode_e;

    // configuration register image, bits 5:0
    typedef struct packed {
        grp_mode_e   mode;
        logic [3:0]  range_x2;
    } cfg_t;

    // reference selection, bit 0 = pair A/B
    typedef struct packed {
        logic cd;
        logic ab;
    } vref_t;

    typedef struct packed {
        logic                valid;
        logic [CH_IDX_W-1:0] ch;
    } data_wr_t;

    // channels refreshed by a data write to channel ch under mode m
    function automatic logic [NUM_CH-1:0] grp_mask(grp_mode_e m, logic [CH_IDX_W-1:0] ch);
        logic [NUM_CH-1:0] r;
        r = '0;
        unique case (m)
            GRP_SINGLE: r[ch] = 1'b1;
            GRP_PAIR:   if (ch[0]) begin
                            r[ch]        = 1'b1;
                            r[ch - 2'd1] = 1'b1;
                        end
            GRP_ALL:    if (ch == 2'd3) r = '1;
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], pin_n};
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R8

endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
#(
    parameter int                DATA_W   = 12,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CH_BASE  = 8'h10,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h1B,
    parameter logic [ADDR_W-1:0] STB_ADDR = 8'h1C
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output cfg_t                          cfg,
    output vref_t                         vref,
    output logic [NUM_CH-1:0][DATA_W-1:0] hold,
    output data_wr_t                      dwr,
    output logic                          stb_wr,
    output logic [NUM_CH-1:0]             stb_bits
);
    logic [ADDR_W-1:0]   ch_off;
    logic                hit_ch, hit_cfg, hit_stb;
    logic [CH_IDX_W-1:0] ch_idx;

    assign ch_off  = bus_addr - CH_BASE;
    assign hit_ch  = (ch_off < ADDR_W'(NUM_CH));
    assign ch_idx  = ch_off[CH_IDX_W-1:0];
    assign hit_cfg = (bus_addr == CFG_ADDR);
    assign hit_stb = (bus_addr == STB_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            vref <= '0;
        end else if (bus_wr) begin
            if (hit_cfg) cfg  <= cfg_t'(bus_wdata[5:0]);
            if (hit_stb) vref <= vref_t'(bus_wdata[5:4]);
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)
                hold[g] <= '0;
            else if (bus_wr && hit_ch && ch_idx == CH_IDX_W'(g))
                hold[g] <= bus_wdata;
        end
    end

    assign dwr.valid = bus_wr & hit_ch;
    assign dwr.ch    = ch_idx;
    assign stb_wr    = bus_wr & hit_stb;
    assign stb_bits  = bus_wdata[NUM_CH-1:0];

    always_comb begin
        bus_rdata = '0;
        if (hit_ch)       bus_rdata = hold[ch_idx];
        else if (hit_cfg) bus_rdata = DATA_W'(cfg);
        else if (hit_stb) bus_rdata = DATA_W'({vref, 4'b0000});
    end

    AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        hit_cfg |-> bus_rdata[7:6] == 2'b00); // R2
    AST_STB_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hit_stb |-> bus_rdata[3:0] == 4'h0 && bus_rdata[7:6] == 2'b00); // R7

endmodule

// File: rtl/qdac_trigger.sv
module qdac_trigger
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  grp_mode_e         mode,
    input  logic              pin_en,
    input  logic              pin_fall,
    input  data_wr_t          dwr,
    input  logic              stb_wr,
    input  logic [NUM_CH-1:0] stb_bits,
    output logic [NUM_CH-1:0] load_pend
);
    logic [NUM_CH-1:0] req;

    always_comb begin
        req = '0;
        if (pin_en) begin
            if (pin_fall) req = '1;
        end else if (mode == GRP_STROBE) begin
            if (stb_wr) req = stb_bits;
        end else if (dwr.valid) begin
            req = grp_mask(mode, dwr.ch);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) load_pend <= '0;
        else     load_pend <= req;
    end

    AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!pin_en && mode == GRP_PAIR) |-> ($countones(req) == 0 || $countones(req) == 2)); // R4
    AST_ALL_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!pin_en && mode == GRP_ALL) |-> ($countones(req) == 0 || $countones(req) == NUM_CH)); // R5
    AST_PIN_GATES: assert property (@(posedge clk) disable iff (rst)
        (pin_en && !pin_fall) |=> load_pend == '0); // R8
    AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (!pin_en && mode == GRP_SINGLE) |-> $onehot0(req)); // R3

endmodule

// File: rtl/qdac_out_bank.sv
module qdac_out_bank
    import qdac_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH-1:0]             load_pend,
    input  logic [NUM_CH-1:0][DATA_W-1:0] hold,
    output logic [NUM_CH-1:0][DATA_W-1:0] code
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst)               code[g] <= '0;
            else if (load_pend[g]) code[g] <= hold[g];
        end

        AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
            !load_pend[g] |=> $stable(code[g])); // R9
        AST_LOAD_TAKES_HOLD: assert property (@(posedge clk) disable iff (rst)
            load_pend[g] |=> code[g] == $past(hold[g])); // R9
    end

endmodule

// File: rtl/qdac_load_ctrl.sv
module qdac_load_ctrl
    import qdac_pkg::*;
#(
    parameter int                DATA_W      = 12,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CH_BASE     = 8'h10,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h1B,
    parameter logic [ADDR_W-1:0] STB_ADDR    = 8'h1C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     ext_load_en,
    input  logic                     ext_load_n,
    output logic [NUM_CH*DATA_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        range_x2,
    output logic [1:0]               vref_int
);
    cfg_t                          cfg;
    vref_t                         vref;
    logic [NUM_CH-1:0][DATA_W-1:0] hold;
    logic [NUM_CH-1:0][DATA_W-1:0] code;
    data_wr_t                      dwr;
    logic                          stb_wr;
    logic [NUM_CH-1:0]             stb_bits;
    logic [NUM_CH-1:0]             load_pend;
    logic                          pin_fall;

    qdac_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE),
        .CFG_ADDR(CFG_ADDR), .STB_ADDR(STB_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg(cfg), .vref(vref),
        .hold(hold), .dwr(dwr), .stb_wr(stb_wr), .stb_bits(stb_bits)
    );

    qdac_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_n(ext_load_n), .fall(pin_fall)
    );

    qdac_trigger u_trig (
        .clk(clk), .rst(rst), .mode(cfg.mode), .pin_en(ext_load_en),
        .pin_fall(pin_fall), .dwr(dwr), .stb_wr(stb_wr), .stb_bits(stb_bits),
        .load_pend(load_pend)
    );

    qdac_out_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst(rst), .load_pend(load_pend), .hold(hold), .code(code)
    );

    assign dac_code = code;
    assign range_x2 = cfg.range_x2;
    assign vref_int = {vref.cd, vref.ab};

    AST_RANGE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == CFG_ADDR) |=> range_x2 == $past(bus_wdata[3:0])); // R2

endmodule

// File: tb/qdac_load_ctrl_bench.sv
module qdac_load_ctrl_bench;
    localparam int DW = 12;
    localparam logic [7:0] CHB = 8'h10, CFG = 8'h1B, STB = 8'h1C, MISS = 8'h40;

    logic clk = 1'b0, rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic ext_load_en = 1'b0, ext_load_n = 1'b1;
    logic [4*DW-1:0] dac_code;
    logic [3:0] range_x2;
    logic [1:0] vref_int;

    int errors = 0, checks = 0;
    logic [DW-1:0] hold_m [4];
    logic [DW-1:0] out_m [4];
    logic [5:0] cfg_m;
    logic [1:0] vref_m;

    always #4 clk = ~clk;

    qdac_load_ctrl u_qdac_load_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_load_en(ext_load_en),
        .ext_load_n(ext_load_n), .dac_code(dac_code), .range_x2(range_x2),
        .vref_int(vref_int)
    );

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_mask(logic [1:0] mode, int c);
        case (mode)
            2'd0: return 4'(1 << c);
            2'd1: return (c == 1) ? 4'b0011 : (c == 3) ? 4'b1100 : 4'b0000;
            2'd2: return (c == 3) ? 4'b1111 : 4'b0000;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic cmp_outs(string req);
        for (int c = 0; c < 4; c++)
            chk(req, dac_code[c*DW +: DW], out_m[c]);
        chk(req, range_x2, cfg_m[3:0]);
        chk(req, vref_int, vref_m);
    endtask

    // model update, then drive one write; returns after the second edge
    task automatic wr(logic [7:0] a, logic [DW-1:0] d);
        logic [3:0] m = 4'b0;
        if (a >= CHB && a < CHB + 8'd4) begin
            hold_m[a - CHB] = d;
            m = exp_mask(cfg_m[5:4], int'(a - CHB));
        end else if (a == STB) begin
            vref_m = d[5:4];
            if (cfg_m[5:4] == 2'b11) m = d[3:0];
        end else if (a == CFG) begin
            cfg_m = d[5:0];
        end
        if (ext_load_en) m = 4'b0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = MISS;
        @(negedge clk);
        for (int c = 0; c < 4; c++) if (m[c]) out_m[c] = hold_m[c];
    endtask

    task automatic rd(string req, logic [7:0] a, logic [DW-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        for (int c = 0; c < 4; c++) begin hold_m[c] = '0; out_m[c] = '0; end
        cfg_m = '0; vref_m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp_outs("R1 reset");
        rd("R1 reset cfg", CFG, '0);
        rd("R1 reset ch", CHB + 8'd2, '0);

        // R9: exact latency in single mode
        @(negedge clk);
        bus_addr = CHB; bus_wdata = 12'hA5C; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 before transfer", dac_code[0 +: DW], 12'h000);
        @(negedge clk);
        chk("R9 after transfer", dac_code[0 +: DW], 12'hA5C);
        hold_m[0] = 12'hA5C; out_m[0] = 12'hA5C;

        // R2 reserved bits dropped
        wr(CFG, 12'hFC5);
        rd("R2 cfg readback", CFG, 12'h005);
        cmp_outs("R2 range");
        // R4 pair mode
        wr(CFG, 12'h010);
        wr(CHB, 12'h111);
        cmp_outs("R4 write A no update");
        wr(CHB + 8'd1, 12'h222);
        cmp_outs("R4 write B updates AB");
        wr(CHB + 8'd3, 12'h444);
        cmp_outs("R4 write D updates CD");
        // R5 all mode
        wr(CFG, 12'h020);
        wr(CHB + 8'd2, 12'h333);
        cmp_outs("R5 write C no update");
        wr(CHB + 8'd3, 12'h555);
        cmp_outs("R5 write D updates all");
        // R6 strobe mode
        wr(CFG, 12'h030);
        wr(CHB, 12'h666);
        cmp_outs("R6 data write no update");
        wr(STB, 12'hFF5);
        cmp_outs("R6 strobe A,C");
        rd("R7 strobe read", STB, 12'h030);
        // R10 miss
        wr(MISS, 12'hFFF);
        cmp_outs("R10 miss");
        rd("R10 miss cfg intact", CFG, 12'h030);
        rd("R11 hold A", CHB, 12'h666);

        // random phase
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 9);
            logic [DW-1:0] d = DW'($urandom);
            if (k < 5)       wr(CHB + 8'($urandom_range(0, 3)), d);
            else if (k < 7)  wr(STB, d);
            else if (k == 7) wr(CFG, d);
            else if (k == 8) wr(MISS + 8'($urandom_range(0, 31)), d);
            else begin
                int c = $urandom_range(0, 3);
                rd("R11 random hold read", CHB + 8'(c), hold_m[c]);
            end
            cmp_outs("R3 R4 R5 R6 random");
        end
        rd("R2 random cfg read", CFG, DW'(cfg_m));
        rd("R7 random strobe read", STB, DW'({vref_m, 4'b0}));

        // R3 directed single mode
        wr(CFG, 12'h000);
        wr(CHB + 8'd2, 12'h7E7);
        cmp_outs("R3 single C");

        // R8 external pin
        ext_load_en = 1'b1;
        wr(CHB + 8'd1, 12'h9A9);
        wr(CFG, 12'h030);
        wr(STB, 12'h00F);
        cmp_outs("R8 writes ignored with pin enabled");
        @(negedge clk);
        ext_load_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int c = 0; c < 4; c++) out_m[c] = hold_m[c];
        cmp_outs("R8 pin fall loads all");
        ext_load_n = 1'b1;
        repeat (4) @(negedge clk);
        ext_load_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule